// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps a free-running time of day as a 48-bit seconds count and a 30-bit nanoseconds count. Once started, it adds a nominal 8 ns on every clock. A fractional rate correction adds or removes one nanosecond whenever a 32-bit sub-nanosecond accumulator overflows. The live value is driven straight out to a timestamp-capture block, so frames can be stamped without going through software.

Software drives the block through a small 16-bit register window. It stages an absolute time and loads it, and it can take a coherent snapshot of the live time and read it back one word at a time. It can also step the time by a signed number of seconds or by a positive number of nanoseconds, set the rate correction, and start, stop or clear the counter. Commands are one-shot bits in a single command word. A command takes effect on the same clock edge as the write that carries it.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the live time is zero, the counter is stopped, and every register reads zero.
- R2: Writing command bit 2 starts the counter and bit 1 stops it; bit 1 wins when both are written. While running with zero rate magnitude, nanoseconds grow by 8 each clock. While stopped, the live time holds.
- R3: Nanoseconds always stay below 1,000,000,000. When an increment reaches that value, the nanoseconds wrap and seconds gain one. Seconds wrap modulo 2^48.
- R4: Writing command bit 4 copies the staged time into the live counter in place of that clock's increment. The staged time is held in five registers: seconds high, middle and low at addresses 1, 2 and 3, and nanoseconds [29:16] and [15:0] at addresses 4 and 5. A staged nanosecond value of one second or more is normalised into the seconds.
- R5: Writing command bit 3 captures the live time as it stood before that edge. Seconds high, middle and low read at addresses 6, 7 and 8, and nanoseconds high and low at addresses 9 and 10. The snapshot holds until the next capture.
- R6: Command bit 5 steps the seconds by the low 4 bits of the step-low register (address 12), in place of that clock's increment. Step-high (address 11) bit 15 set means add, and clear means subtract. The result wraps modulo 2^48.
- R7: Command bit 6 adds {step-high[13:0], step-low} nanoseconds to the live time, in place of that clock's increment. Step-high bit 15 has no effect on this step. The carry goes into the seconds as in R3.
- R8: Each running clock adds the 30-bit magnitude {rate-high[13:0], rate-low} (addresses 13 and 14) to a 32-bit accumulator. On accumulator overflow the increment is 9 ns when rate-high bit 15 is set and 7 ns when it is clear. A zero magnitude gives exactly 8 ns, whatever the direction bit.
- R9: When several time commands share one write, they take priority in the order clear, load, seconds step, nanosecond step. The command register (address 0) always reads zero.
- R10: Command bit 0 clears the live time and the rate accumulator and stops the counter, unless bit 2 is in the same write.
- R11: Registers that take writes read back their stored bits. Nanoseconds-high reads bits [13:0] only. Step-high and rate-high read bits 15 and [13:0]. Writes to the snapshot addresses have no effect, and address 15 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| now_sec | output | 48 | Live seconds |
| now_ns | output | 30 | Live nanoseconds |
| running | output | 1 | Counter is advancing |

## Verification
The hardest states to reach from the ports are the wrap of the 48-bit seconds count and a subtracting seconds step below zero. Counting up to them would take far longer than any test can run. The stimulus instead loads a time a few ticks short of the seconds limit and lets the increment carry through all 48 bits, and it loads a small seconds value before stepping it down by more. The rate path is pushed to overflow by a large magnitude, so that the 9 ns and 7 ns ticks appear within tens of cycles. A behavioural model checks every clock of these stretches.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
    localparam int WORD_W  = 16;
    localparam int SEC_W   = 48;
    localparam int NS_W    = 30;
    localparam int ADDR_W  = 4;
    localparam int NS_HI_W = NS_W - WORD_W;
    localparam int DIR_BIT = WORD_W - 1;
    localparam int SEC_MID_LSB = WORD_W;
    localparam int SEC_HI_LSB  = 2 * WORD_W;

    localparam logic [NS_W:0] ONE_SEC_NS = 31'd1_000_000_000;
    localparam logic [NS_W:0] TWO_SEC_NS = 31'd2_000_000_000;

    typedef enum logic [ADDR_W-1:0] {
        A_CMD        = 4'd0,
        A_SET_SEC_HI = 4'd1,
        A_SET_SEC_MD = 4'd2,
        A_SET_SEC_LO = 4'd3,
        A_SET_NS_HI  = 4'd4,
        A_SET_NS_LO  = 4'd5,
        A_SNP_SEC_HI = 4'd6,
        A_SNP_SEC_MD = 4'd7,
        A_SNP_SEC_LO = 4'd8,
        A_SNP_NS_HI  = 4'd9,
        A_SNP_NS_LO  = 4'd10,
        A_STEP_HI    = 4'd11,
        A_STEP_LO    = 4'd12,
        A_RATE_HI    = 4'd13,
        A_RATE_LO    = 4'd14
    } reg_addr_e;

    // bit 0 is the last member
    typedef struct packed {
        logic step_ns;
        logic step_sec;
        logic load;
        logic snap;
        logic start;
        logic stop;
        logic clr;
    } cmd_t;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } tod_t;
endpackage

// File: rtl/ptc_regs.sv
module ptc_regs
    import ptc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  tod_t              live,
    output logic [WORD_W-1:0] rdata,
    output cmd_t              cmd,
    output tod_t              set_tod,
    output logic              step_up,
    output logic [NS_W-1:0]   step_val,
    output logic              rate_fast,
    output logic [NS_W-1:0]   rate_mag,
    output tod_t              snap_tod
);
    typedef struct packed {
        tod_t            set;
        logic            step_up;
        logic [NS_W-1:0] step;
        logic            rate_fast;
        logic [NS_W-1:0] rate;
        tod_t            snap;
    } regs_t;

    localparam int PAD_W = WORD_W - NS_HI_W;

    regs_t q, d;

    always_comb begin
        d   = q;
        cmd = '0;
        if (wr_en) begin
            case (addr)
                A_CMD:        cmd = cmd_t'(wdata[$bits(cmd_t)-1:0]);
                A_SET_SEC_HI: d.set.sec[SEC_HI_LSB +: WORD_W]  = wdata;
                A_SET_SEC_MD: d.set.sec[SEC_MID_LSB +: WORD_W] = wdata;
                A_SET_SEC_LO: d.set.sec[0 +: WORD_W]           = wdata;
                A_SET_NS_HI:  d.set.ns[WORD_W +: NS_HI_W]      = wdata[NS_HI_W-1:0];
                A_SET_NS_LO:  d.set.ns[0 +: WORD_W]            = wdata;
                A_STEP_HI: begin
                    d.step_up              = wdata[DIR_BIT];
                    d.step[WORD_W +: NS_HI_W] = wdata[NS_HI_W-1:0];
                end
                A_STEP_LO:    d.step[0 +: WORD_W] = wdata;
                A_RATE_HI: begin
                    d.rate_fast            = wdata[DIR_BIT];
                    d.rate[WORD_W +: NS_HI_W] = wdata[NS_HI_W-1:0];
                end
                A_RATE_LO:    d.rate[0 +: WORD_W] = wdata;
                default: ;
            endcase
        end
        if (cmd.snap) d.snap = live;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_SET_SEC_HI: rdata = q.set.sec[SEC_HI_LSB +: WORD_W];
            A_SET_SEC_MD: rdata = q.set.sec[SEC_MID_LSB +: WORD_W];
            A_SET_SEC_LO: rdata = q.set.sec[0 +: WORD_W];
            A_SET_NS_HI:  rdata = {{PAD_W{1'b0}}, q.set.ns[WORD_W +: NS_HI_W]};
            A_SET_NS_LO:  rdata = q.set.ns[0 +: WORD_W];
            A_SNP_SEC_HI: rdata = q.snap.sec[SEC_HI_LSB +: WORD_W];
            A_SNP_SEC_MD: rdata = q.snap.sec[SEC_MID_LSB +: WORD_W];
            A_SNP_SEC_LO: rdata = q.snap.sec[0 +: WORD_W];
            A_SNP_NS_HI:  rdata = {{PAD_W{1'b0}}, q.snap.ns[WORD_W +: NS_HI_W]};
            A_SNP_NS_LO:  rdata = q.snap.ns[0 +: WORD_W];
            A_STEP_HI:    rdata = {q.step_up, {(PAD_W-1){1'b0}}, q.step[WORD_W +: NS_HI_W]};
            A_STEP_LO:    rdata = q.step[0 +: WORD_W];
            A_RATE_HI:    rdata = {q.rate_fast, {(PAD_W-1){1'b0}}, q.rate[WORD_W +: NS_HI_W]};
            A_RATE_LO:    rdata = q.rate[0 +: WORD_W];
            default:      rdata = '0;
        endcase
    end

    assign set_tod   = q.set;
    assign step_up   = q.step_up;
    assign step_val  = q.step;
    assign rate_fast = q.rate_fast;
    assign rate_mag  = q.rate;
    assign snap_tod  = q.snap;
endmodule

// File: rtl/ptc_rate_acc.sv
module ptc_rate_acc
    import ptc_pkg::*;
#(
    parameter int FRAC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            advance,
    input  logic [NS_W-1:0] mag,
    output logic            carry
);
    localparam int PAD_W = FRAC_W + 1 - NS_W;

    logic [FRAC_W-1:0] acc_q, acc_d;
    logic [FRAC_W:0]   sum;

    generate
        if (PAD_W > 0) begin : g_wide
            assign sum = {1'b0, acc_q} + {{PAD_W{1'b0}}, mag};
        end else begin : g_narrow
            assign sum = {1'b0, acc_q} + mag[FRAC_W:0];
        end
    endgenerate

    always_comb begin
        carry = sum[FRAC_W];
        if (clear)        acc_d = '0;
        else if (advance) acc_d = sum[FRAC_W-1:0];
        else              acc_d = acc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/ptc_time_core.sv
module ptc_time_core
    import ptc_pkg::*;
#(
    parameter int INC_NS     = 8,
    parameter int STEP_SEC_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  cmd_t            cmd,
    input  tod_t            set_tod,
    input  logic            step_up,
    input  logic [NS_W-1:0] step_val,
    input  logic            frac_carry,
    input  logic            rate_fast,
    output tod_t            now,
    output logic            running,
    output logic            advance
);
    typedef struct packed {
        tod_t t;
        logic run;
    } core_t;

    localparam logic [NS_W:0] INC_W = (NS_W+1)'(INC_NS);

    core_t q, d;
    logic [NS_W:0]    ns_sum;
    logic [NS_W:0]    ns_less1;
    logic [NS_W:0]    ns_less2;
    logic [SEC_W-1:0] sec_base;
    logic [SEC_W-1:0] sec_mag;
    logic [NS_W:0]    nudge_up;
    logic [NS_W:0]    nudge_dn;

    always_comb begin
        d        = q;
        advance  = 1'b0;
        sec_mag  = {{(SEC_W-STEP_SEC_W){1'b0}}, step_val[STEP_SEC_W-1:0]};
        nudge_up = {{NS_W{1'b0}}, frac_carry & rate_fast};
        nudge_dn = {{NS_W{1'b0}}, frac_carry & ~rate_fast};
        ns_sum   = {1'b0, q.t.ns};
        sec_base = q.t.sec;

        // time commands, highest priority first
        if (cmd.clr) begin
            ns_sum   = '0;
            sec_base = '0;
        end else if (cmd.load) begin
            ns_sum   = {1'b0, set_tod.ns};
            sec_base = set_tod.sec;
        end else if (cmd.step_sec) begin
            sec_base = step_up ? (q.t.sec + sec_mag) : (q.t.sec - sec_mag);
        end else if (cmd.step_ns) begin
            ns_sum = {1'b0, q.t.ns} + {1'b0, step_val};
        end else if (q.run) begin
            advance = 1'b1;
            ns_sum  = {1'b0, q.t.ns} + INC_W + nudge_up - nudge_dn;
        end

        // fold whole seconds out of the nanosecond sum
        ns_less1 = ns_sum - ONE_SEC_NS;
        ns_less2 = ns_sum - TWO_SEC_NS;
        if (ns_sum >= TWO_SEC_NS) begin
            d.t.ns  = ns_less2[NS_W-1:0];
            d.t.sec = sec_base + SEC_W'(2);
        end else if (ns_sum >= ONE_SEC_NS) begin
            d.t.ns  = ns_less1[NS_W-1:0];
            d.t.sec = sec_base + SEC_W'(1);
        end else begin
            d.t.ns  = ns_sum[NS_W-1:0];
            d.t.sec = sec_base;
        end

        if (cmd.stop)       d.run = 1'b0;
        else if (cmd.start) d.run = 1'b1;
        else if (cmd.clr)   d.run = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign now     = q.t;
    assign running = q.run;
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
    import ptc_pkg::*;
#(
    parameter int INC_NS     = 8,
    parameter int FRAC_W     = 32,
    parameter int STEP_SEC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic [SEC_W-1:0]  now_sec,
    output logic [NS_W-1:0]   now_ns,
    output logic              running
);
    cmd_t            cmd;
    tod_t            set_tod;
    tod_t            snap_tod;
    tod_t            live;
    logic            step_up;
    logic [NS_W-1:0] step_val;
    logic            rate_fast;
    logic [NS_W-1:0] rate_mag;
    logic            frac_carry;
    logic            advance;

    ptc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .live      (live),
        .rdata     (reg_rdata),
        .cmd       (cmd),
        .set_tod   (set_tod),
        .step_up   (step_up),
        .step_val  (step_val),
        .rate_fast (rate_fast),
        .rate_mag  (rate_mag),
        .snap_tod  (snap_tod)
    );

    ptc_rate_acc #(.FRAC_W(FRAC_W)) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cmd.clr),
        .advance (advance),
        .mag     (rate_mag),
        .carry   (frac_carry)
    );

    ptc_time_core #(.INC_NS(INC_NS), .STEP_SEC_W(STEP_SEC_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .set_tod    (set_tod),
        .step_up    (step_up),
        .step_val   (step_val),
        .frac_carry (frac_carry),
        .rate_fast  (rate_fast),
        .now        (live),
        .running    (running),
        .advance    (advance)
    );

    assign now_sec = live.sec;
    assign now_ns  = live.ns;
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker
    import ptc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [WORD_W-1:0] reg_rdata,
    input logic [SEC_W-1:0]  now_sec,
    input logic [NS_W-1:0]   now_ns,
    input logic              running,
    input tod_t              set_tod,
    input tod_t              snap_tod
);
    logic cmd_wr;
    logic quiet;
    assign cmd_wr = reg_wr && (reg_addr == A_CMD);
    assign quiet  = !(cmd_wr && (reg_wdata[0] || reg_wdata[4] || reg_wdata[5] || reg_wdata[6]));

    p_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && quiet && now_ns < 30'd999_999_990) |=>
        ((now_ns - $past(now_ns)) >= 30'd7 && (now_ns - $past(now_ns)) <= 30'd9
         && now_sec == $past(now_sec)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && quiet) |=> ($stable(now_ns) && $stable(now_sec)));

    p_ns_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        now_ns < 30'd1_000_000_000);

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !reg_wdata[0] && reg_wdata[4] && set_tod.ns < 30'd1_000_000_000) |=>
        (now_sec == $past(set_tod.sec) && now_ns == $past(set_tod.ns)));

    p_snap_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && reg_wdata[3]) |=>
        (snap_tod.sec == $past(now_sec) && snap_tod.ns == $past(now_ns)));

    p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_wr && reg_wdata[3]) |=> $stable(snap_tod));

    p_cmd_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CMD) |-> (reg_rdata == '0));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && reg_wdata[0]) |=> (now_sec == '0 && now_ns == '0));
endmodule

bind ptp_time_counter ptc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .now_sec   (now_sec),
    .now_ns    (now_ns),
    .running   (running),
    .set_tod   (set_tod),
    .snap_tod  (snap_tod)
);

// File: tb/sim_ptp_time_counter.sv
`timescale 1ns/1ps
module sim_ptp_time_counter;
    localparam longint NSPS   = 64'd1000000000;
    localparam longint MASK48 = (64'd1 << 48) - 1;
    localparam longint TWO32  = 64'd1 << 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic [47:0] now_sec;
    logic [29:0] now_ns;
    logic        running;

    always #10 clk = ~clk;

    ptp_time_counter u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .now_sec(now_sec), .now_ns(now_ns), .running(running)
    );

    int     checks = 0;
    int     errors = 0;
    string  req = "R1";
    bit     cmp_en = 1'b0;
    bit     finished = 1'b0;

    // reference model state
    longint m_sec, m_ns, m_acc;
    bit     m_run;
    longint s_sec, s_ns;
    bit     st_up;
    longint st_val;
    bit     rt_fast;
    longint rt_mag;
    longint sn_sec, sn_ns;

    task automatic check(input string r, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    function automatic longint put_word(input longint v, input int lsb, input longint w);
        return (v & ~(64'hFFFF << lsb)) | ((w & 64'hFFFF) << lsb);
    endfunction

    always @(posedge clk) begin : model
        logic [6:0] c;
        longint mag;
        longint inc;
        if (!rst_n) begin
            m_sec = 0; m_ns = 0; m_acc = 0; m_run = 0;
            s_sec = 0; s_ns = 0; st_up = 0; st_val = 0;
            rt_fast = 0; rt_mag = 0; sn_sec = 0; sn_ns = 0;
        end else begin
            c = (reg_wr && reg_addr == 4'd0) ? reg_wdata[6:0] : 7'd0;
            if (c[3]) begin sn_sec = m_sec; sn_ns = m_ns; end
            if (c[0]) begin
                m_sec = 0; m_ns = 0; m_acc = 0;
            end else if (c[4]) begin
                m_sec = s_sec; m_ns = s_ns;
                while (m_ns >= NSPS) begin m_ns -= NSPS; m_sec = (m_sec + 1) & MASK48; end
            end else if (c[5]) begin
                mag = st_val % 16;
                m_sec = (st_up ? m_sec + mag : m_sec - mag) & MASK48;
            end else if (c[6]) begin
                m_ns += st_val;
                while (m_ns >= NSPS) begin m_ns -= NSPS; m_sec = (m_sec + 1) & MASK48; end
            end else if (m_run) begin
                m_acc += rt_mag;
                inc = 8;
                if (m_acc >= TWO32) begin m_acc -= TWO32; inc = rt_fast ? 9 : 7; end
                m_ns += inc;
                if (m_ns >= NSPS) begin m_ns -= NSPS; m_sec = (m_sec + 1) & MASK48; end
            end
            if (c[1])      m_run = 0;
            else if (c[2]) m_run = 1;
            else if (c[0]) m_run = 0;
            if (reg_wr) begin
                case (reg_addr)
                    4'd1:  s_sec = put_word(s_sec, 32, longint'(reg_wdata));
                    4'd2:  s_sec = put_word(s_sec, 16, longint'(reg_wdata));
                    4'd3:  s_sec = put_word(s_sec, 0, longint'(reg_wdata));
                    4'd4:  s_ns  = put_word(s_ns, 16, longint'(reg_wdata) & 64'h3FFF);
                    4'd5:  s_ns  = put_word(s_ns, 0, longint'(reg_wdata));
                    4'd11: begin st_up = reg_wdata[15]; st_val = put_word(st_val, 16, longint'(reg_wdata) & 64'h3FFF); end
                    4'd12: st_val = put_word(st_val, 0, longint'(reg_wdata));
                    4'd13: begin rt_fast = reg_wdata[15]; rt_mag = put_word(rt_mag, 16, longint'(reg_wdata) & 64'h3FFF); end
                    4'd14: rt_mag = put_word(rt_mag, 0, longint'(reg_wdata));
                    default: ;
                endcase
            end
        end
        #2;
        if (cmp_en && !finished) begin
            check(req, "live seconds", longint'(now_sec), m_sec);
            check(req, "live nanoseconds", longint'(now_ns), m_ns);
            check(req, "running flag", longint'(running), longint'(m_run));
        end
    end

    task automatic wr(input logic [3:0] a, input longint d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d[15:0];
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input longint exp, input string r, input string what);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(r, what, longint'(reg_rdata), exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stage(input longint s, input longint n);
        wr(4'd1, (s >> 32) & 64'hFFFF);
        wr(4'd2, (s >> 16) & 64'hFFFF);
        wr(4'd3, s & 64'hFFFF);
        wr(4'd4, (n >> 16) & 64'hFFFF);
        wr(4'd5, n & 64'hFFFF);
    endtask

    task automatic check_snap(input string r);
        rd(4'd6,  (sn_sec >> 32) & 64'hFFFF, r, "snapshot sec high");
        rd(4'd7,  (sn_sec >> 16) & 64'hFFFF, r, "snapshot sec mid");
        rd(4'd8,  sn_sec & 64'hFFFF, r, "snapshot sec low");
        rd(4'd9,  (sn_ns >> 16) & 64'h3FFF, r, "snapshot ns high");
        rd(4'd10, sn_ns & 64'hFFFF, r, "snapshot ns low");
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        longint snap_keep;
        // R1: reset state
        idle(3);
        check("R1", "seconds in reset", longint'(now_sec), 0);
        check("R1", "nanoseconds in reset", longint'(now_ns), 0);
        @(negedge clk); rst_n = 1'b1;
        for (int a = 0; a < 16; a++) rd(a[3:0], 0, "R1", "register after reset");
        idle(4);
        check("R1", "stopped after reset", longint'(running), 0);
        check("R1", "time held after reset", longint'(now_ns), 0);
        cmp_en = 1'b1;

        // R2: start, nominal tick, stop wins over start
        req = "R2";
        wr(4'd0, 16'h0004);
        idle(20);
        check("R2", "ns after running", longint'(now_ns) % 8, 0);
        wr(4'd0, 16'h0006);
        idle(6);
        check("R2", "stopped by combined write", longint'(running), 0);
        wr(4'd0, 16'h0004);
        idle(5);

        // R4 / R3: load near the second boundary and tick over it
        req = "R4";
        stage(64'h0001_0002_0003, 999999960);
        wr(4'd0, 16'h0010);
        req = "R3";
        idle(12);
        // R3: seconds wrap modulo 2^48
        stage(MASK48, 999999990);
        wr(4'd0, 16'h0010);
        idle(6);
        check("R3", "seconds wrapped to zero", longint'(now_sec), 0);
        // R4: oversize staged nanoseconds normalised
        req = "R4";
        stage(64'd5, 64'h3FFF_FFFF);
        wr(4'd0, 16'h0010);
        idle(3);

        // R5: snapshot and its stability
        req = "R5";
        wr(4'd0, 16'h0008);
        check_snap("R5");
        snap_keep = sn_ns;
        idle(10);
        wr(4'd6, 16'h1234);
        rd(4'd10, snap_keep & 64'hFFFF, "R5", "snapshot held after reads and write");
        // snapshot together with load sees old time
        stage(64'd77, 500);
        wr(4'd0, 16'h0018);
        check_snap("R5");

        // R6: seconds steps
        req = "R6";
        wr(4'd11, 16'h8000);
        wr(4'd12, 16'h0007);
        wr(4'd0, 16'h0020);
        wr(4'd12, 16'hFFF5);
        wr(4'd0, 16'h0020);
        stage(64'd3, 100);
        wr(4'd0, 16'h0010);
        wr(4'd11, 16'h0000);
        wr(4'd12, 16'h0005);
        wr(4'd0, 16'h0020);
        idle(3);
        check("R6", "subtract wrapped high", longint'(now_sec), MASK48 - 1);

        // R7: nanosecond step with carry, direction bit ignored
        req = "R7";
        wr(4'd11, 16'h0000 | ((999999999 >> 16) & 16'h3FFF));
        wr(4'd12, 999999999 & 16'hFFFF);
        wr(4'd0, 16'h0040);
        wr(4'd11, 16'h8000 | ((123456 >> 16) & 16'h3FFF));
        wr(4'd12, 123456 & 16'hFFFF);
        wr(4'd0, 16'h0040);
        idle(4);

        // R8: rate correction both directions, zero magnitude nominal
        req = "R8";
        wr(4'd14, 16'h0000);
        wr(4'd13, 16'hA000);
        idle(40);
        wr(4'd13, 16'h2000);
        idle(40);
        wr(4'd13, 16'h8000);
        idle(20);
        wr(4'd13, 16'h0000);

        // R9: priorities and command read-back
        req = "R9";
        stage(64'd1000, 2000);
        wr(4'd11, 16'h8000);
        wr(4'd12, 16'h0003);
        wr(4'd0, 16'h0070);
        idle(2);
        wr(4'd0, 16'h0011);
        rd(4'd0, 0, "R9", "command register");
        wr(4'd0, 16'h0060);
        idle(2);

        // R10: clear command
        req = "R10";
        wr(4'd0, 16'h0004);
        idle(10);
        wr(4'd0, 16'h0001);
        idle(3);
        check("R10", "clear stops", longint'(running), 0);
        wr(4'd0, 16'h0005);
        idle(10);
        check("R10", "clear with start runs", longint'(running), 1);

        // R11: read-back masks
        req = "R11";
        wr(4'd4, 16'hFFFF);
        rd(4'd4, 16'h3FFF, "R11", "set ns high mask");
        wr(4'd11, 16'hFFFF);
        rd(4'd11, 16'hBFFF, "R11", "step high mask");
        wr(4'd13, 16'h7FFF);
        rd(4'd13, 16'h3FFF, "R11", "rate high mask");
        wr(4'd1, 16'hABCD);
        rd(4'd1, 16'hABCD, "R11", "set sec high");
        rd(4'd15, 0, "R11", "unused address");
        idle(4);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule